// File: doc/BRIEF.md
# Single-Register Accumulator Operation Unit

This unit carries out the short one-operand data operations of a 16-bit instruction class on a single 32-bit data register. The instruction decoder presents the current value of the register, the register index, a one-bit group select and a 4-bit secondary code, and raises a valid strobe. One clock later the unit raises `done` and, when the operation writes, a one-cycle write-enable pulse with the register index and the new value for the register file.

Two groups of operations are supported. The accumulate group negates the operand by subtracting it from zero, or clamps it to one of four ranges: signed byte, unsigned byte, signed halfword or unsigned halfword. A single two-compare clamp structure, parameterized by width and signedness, serves all four ranges. The complement group writes the bitwise inverse of the operand. Its code 0 is a no-write encoding. Codes that are not defined still complete with `done` and leave the register untouched.

Top module: `short_acc_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done` and `wr_en` are 0 and `wr_data` and `wr_addr` are 0.
- R2: `done` is high in exactly the cycles that follow a cycle with `in_valid` high, whatever the operation.
- R3: `wr_en` is high only in a cycle where `done` is high. When it is high, `wr_addr` equals the `in_addr` that was sampled with the strobe.
- R4: Accumulate group (`in_grp`=0) with code 0 writes 0 minus `in_data`, modulo 2^32.
- R5: Complement group (`in_grp`=1) with any nonzero code writes the bitwise inverse of `in_data`.
- R6: Complement group with code 0 raises `done` but not `wr_en`, and `wr_data` keeps its previous value.
- R7: Accumulate code 1 treats `in_data` as signed and clamps it to [-128, 127]. The lower bound is applied first and the upper bound after it.
- R8: Accumulate code 2 treats `in_data` as unsigned and replaces any value above 255 with 255.
- R9: Accumulate code 3 treats `in_data` as signed and clamps it to [-32768, 32767], applying the lower bound first.
- R10: Accumulate code 4 treats `in_data` as unsigned and replaces any value above 65535 with 65535.
- R11: Accumulate codes 5 to 15 raise `done` without `wr_en`, and `wr_data` keeps its previous value.
- R12: Back-to-back strobes on consecutive cycles each produce their own result in the cycle after their strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| in_grp | input | 1 | Group select: 0 accumulate, 1 complement |
| in_code | input | 4 | Secondary operation code |
| in_addr | input | AW (4) | Index of the register being operated on |
| in_data | input | DW (32) | Current register value |
| done | output | 1 | Completion pulse, one cycle after the strobe |
| wr_en | output | 1 | Register-file write enable pulse |
| wr_addr | output | AW (4) | Register-file write index |
| wr_data | output | DW (32) | Register-file write value |

## Verification
On every cycle the assertions check the timing contract: done follows the strobe, the write pulse falls inside done, and the write index matches the strobed one. They also check that no-write encodings never pulse `wr_en`, and that negation and the byte clamps land on correct values or within the stated ranges. The exact clamp values at and around each boundary (±128, 255, ±32768, 65535, the 32-bit extremes), the held `wr_data` after a no-write operation, and back-to-back streams of mixed operations are shown only by the bench's directed and random scenarios.

// File: rtl/acc_unit_pkg.sv
package acc_unit_pkg;

  typedef enum logic [3:0] {
    ACC_NEG   = 4'd0,
    ACC_SATSB = 4'd1,
    ACC_SATUB = 4'd2,
    ACC_SATSH = 4'd3,
    ACC_SATUH = 4'd4
  } acc_code_e;

  typedef enum logic [2:0] {
    RES_NONE = 3'd0,
    RES_NEG  = 3'd1,
    RES_INV  = 3'd2,
    RES_SB   = 3'd3,
    RES_UB   = 3'd4,
    RES_SH   = 3'd5,
    RES_UH   = 3'd6
  } res_sel_e;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_unit_pkg::*;
(
  input  logic       grp,
  input  logic [3:0] code,
  output res_sel_e   sel,
  output logic       writes
);

  always_comb begin
    sel = RES_NONE;
    if (grp) begin
      if (code != 4'd0) sel = RES_INV;
    end else begin
      case (code)
        ACC_NEG:   sel = RES_NEG;
        ACC_SATSB: sel = RES_SB;
        ACC_SATUB: sel = RES_UB;
        ACC_SATSH: sel = RES_SH;
        ACC_SATUH: sel = RES_UH;
        default:   sel = RES_NONE;
      endcase
    end
    writes = (sel != RES_NONE);
  end

endmodule

// File: rtl/acc_clamp.sv
module acc_clamp #(
  parameter int DW     = 32,
  parameter int BITS   = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic [DW-1:0] x,
  output logic [DW-1:0] y
);

  localparam int EXT = DW - BITS;

  generate
    if (SIGNED) begin : g_signed
      localparam logic [DW-1:0] LO = {{(EXT+1){1'b1}}, {(BITS-1){1'b0}}};
      localparam logic [DW-1:0] HI = {{(EXT+1){1'b0}}, {(BITS-1){1'b1}}};
      logic [DW-1:0] floored;
      always_comb begin
        floored = ($signed(x) < $signed(LO)) ? LO : x;
        y       = ($signed(floored) > $signed(HI)) ? HI : floored;
      end
    end else begin : g_unsigned
      localparam logic [DW-1:0] HI = {{EXT{1'b0}}, {BITS{1'b1}}};
      always_comb y = (x > HI) ? HI : x;
    end
  endgenerate

endmodule

// File: rtl/short_acc_unit.sv
module short_acc_unit
  import acc_unit_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_grp,
  input  logic [3:0]    in_code,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          done,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  res_sel_e      sel;
  logic          writes;
  logic [DW-1:0] sb_v, ub_v, sh_v, uh_v;
  logic [DW-1:0] result;

  acc_decode u_dec (
    .grp   (in_grp),
    .code  (in_code),
    .sel   (sel),
    .writes(writes)
  );

  acc_clamp #(.DW(DW), .BITS(BYTE_W), .SIGNED(1'b1)) u_sb (.x(in_data), .y(sb_v));
  acc_clamp #(.DW(DW), .BITS(BYTE_W), .SIGNED(1'b0)) u_ub (.x(in_data), .y(ub_v));
  acc_clamp #(.DW(DW), .BITS(HALF_W), .SIGNED(1'b1)) u_sh (.x(in_data), .y(sh_v));
  acc_clamp #(.DW(DW), .BITS(HALF_W), .SIGNED(1'b0)) u_uh (.x(in_data), .y(uh_v));

  always_comb begin
    case (sel)
      RES_NEG: result = {DW{1'b0}} - in_data;
      RES_INV: result = ~in_data;
      RES_SB:  result = sb_v;
      RES_UB:  result = ub_v;
      RES_SH:  result = sh_v;
      RES_UH:  result = uh_v;
      default: result = in_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      done  <= in_valid;
      wr_en <= in_valid & writes;
      if (in_valid && writes) begin
        wr_addr <= in_addr;
        wr_data <= result;
      end
    end
  end

endmodule

// File: rtl/short_acc_unit_chk.sv
module short_acc_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_grp,
  input logic [3:0]    in_code,
  input logic [AW-1:0] in_addr,
  input logic [DW-1:0] in_data,
  input logic          done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);

  // R2
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);

  // R2
  done_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid));

  // R3
  wr_inside_done_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

  // R3
  wr_addr_match_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_addr == $past(in_addr));

  // R4
  neg_value_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_grp && in_code == 4'd0) |=> (wr_en && wr_data + $past(in_data) == '0));

  // R6
  inv_zero_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_grp && in_code == 4'd0) |=> (!wr_en && $stable(wr_data)));

  // R7
  sb_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_grp && in_code == 4'd1) |=>
      ($signed(wr_data) >= -128 && $signed(wr_data) <= 127));

  // R8
  ub_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_grp && in_code == 4'd2) |=> (wr_data <= 255));

  // R11
  unused_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_grp && in_code > 4'd4) |=> (!wr_en && $stable(wr_data)));

endmodule

bind short_acc_unit short_acc_unit_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/short_acc_unit_test.sv
module short_acc_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_grp = 1'b0;
  logic [3:0]    in_code = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          done, wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // expected state of the pending operation
  bit            p_valid = 0, p_wr = 0;
  logic [DW-1:0] p_data = '0, last_data = '0;
  logic [AW-1:0] p_addr = '0;
  string         p_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  short_acc_unit #(.DW(DW), .AW(AW)) uut (.*);

  function automatic logic [DW:0] model(input logic g, input logic [3:0] c, input logic [DW-1:0] d);
    int signed s;
    s = $signed(d);
    if (g) return (c == 0) ? {1'b0, d} : {1'b1, ~d};
    case (c)
      4'd0: return {1'b1, 32'd0 - d};
      4'd1: return {1'b1, (s < -128) ? 32'hffffff80 : (s > 127) ? 32'd127 : d};
      4'd2: return {1'b1, (d > 32'd255) ? 32'd255 : d};
      4'd3: return {1'b1, (s < -32768) ? 32'hffff8000 : (s > 32767) ? 32'd32767 : d};
      4'd4: return {1'b1, (d > 32'd65535) ? 32'd65535 : d};
      default: return {1'b0, d};
    endcase
  endfunction

  function automatic string tag_of(input logic g, input logic [3:0] c);
    if (g) return (c == 0) ? "R6" : "R5";
    case (c)
      4'd0: return "R4";
      4'd1: return "R7";
      4'd2: return "R8";
      4'd3: return "R9";
      4'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // check the previous operation's outputs, then drive the next one (called at negedge)
  task automatic step(input bit v, input logic g, input logic [3:0] c,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW:0] m;
    check("R2", {31'd0, done}, {31'd0, p_valid});
    if (p_valid) begin
      check({p_tag, " (R12 stream) wr_en"}, {31'd0, wr_en}, {31'd0, p_wr});
      if (p_wr) begin
        check(p_tag, wr_data, p_data);
        check("R3", {28'd0, wr_addr}, {28'd0, p_addr});
        last_data = p_data;
      end else begin
        check({p_tag, " hold"}, wr_data, last_data);
      end
    end else begin
      check("R3", {31'd0, wr_en}, 32'd0);
    end
    m = model(g, c, d);
    p_valid = v;
    p_wr    = v && m[DW];
    p_data  = m[DW-1:0];
    p_addr  = a;
    p_tag   = tag_of(g, c);
    in_valid = v; in_grp = g; in_code = c; in_addr = a; in_data = d;
    @(negedge clk);
  endtask

  logic [DW-1:0] corners [15] = '{32'h0, 32'h1, 32'h7f, 32'h80, 32'hff, 32'h100,
    32'hffffff80, 32'hffffff7f, 32'h7fff, 32'h8000, 32'hffff, 32'h10000,
    32'h80000000, 32'h7fffffff, 32'hffffffff};

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 wr_en", {31'd0, wr_en}, 32'd0);
    check("R1 wr_data", wr_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after", {31'd0, done | wr_en}, 32'd0);
    check("R1 addr", {28'd0, wr_addr}, 32'd0);

    // directed: every corner value through every defined code, back to back (R12)
    foreach (corners[i]) begin
      for (int c = 0; c < 5; c++)
        step(1'b1, 1'b0, 4'(c), 4'(i), corners[i]);
      step(1'b1, 1'b1, 4'd3, 4'(i), corners[i]);
      step(1'b1, 1'b1, 4'd0, 4'(i), corners[i]);   // R6 no write
      step(1'b1, 1'b0, 4'd9, 4'(i), corners[i]);   // R11 no write
      step(1'b0, 1'b0, 4'd0, 4'(i), corners[i]);   // idle
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [DW-1:0] d;
      int k;
      k = $urandom_range(0, 3);
      d = $urandom();
      if (k == 1) d = 32'($signed(16'($urandom())));
      else if (k == 2) d = 32'($signed(8'($urandom())));
      step(($urandom_range(0, 4) != 0), 1'($urandom()), 4'($urandom_range(0, 15) % 7 == 6 ?
           $urandom_range(5, 15) : $urandom_range(0, 5) % 5), 4'($urandom()), d);
    end
    step(1'b0, 1'b0, 4'd0, '0, '0);
    step(1'b0, 1'b0, 4'd0, '0, '0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule